// File: doc/BRIEF.md
# Serial Programming Target Port

This block is the device-side end of a four-wire serial programming link. A host clocks 32-bit instructions in on `mosi` with `sck`, most significant bit first. While each byte goes in, the port shifts out on `miso` the byte it received just before, so the host can confirm bit alignment by watching the second key byte of the unlock instruction come back during the third byte. Until that unlock instruction has been seen, every other instruction is dropped. A pulse on `link_rst` throws away a partial frame and locks the port again, so the host can resynchronise.

Once unlocked, the port fills two page buffers. The first holds 16-bit program words addressed by word index, with low and high bytes loaded by separate instructions. The second holds data bytes and keeps a per-entry "loaded" flag. A page-write instruction copies a buffer into a behavioural memory array. For data memory, only flagged entries are copied. Single data bytes can also be written directly, and both arrays can be read back. Each write holds `busy` high for `WRITE_CYCLES` clock cycles, and the port drops load and write instructions that finish during that window.

The link is sampled in the `clk` domain, so `sck` must run well below `clk` (at least four `clk` cycles per `sck` phase).

Top module: `spiprog_target`

## Requirements
- R1: After reset, `busy` is 0, `miso` is 0, the port is locked, and every location of both memories reads back as all ones (0xFF per byte).
- R2: While bytes 2, 3 and 4 of any frame are shifted in, `miso` returns the byte received immediately before, MSB first. During byte 1, `miso` returns 0x00. The one exception is the byte-4 read data of R8. In particular, during byte 3 of the unlock frame `AC 53 xx xx`, `miso` returns 0x53.
- R3: Only a frame whose first two bytes are 0xAC, 0x53 unlocks the port. Frames completed while locked have no effect and start no write. Asserting `link_rst` clears the bit count, the pending `miso` byte and the unlock state.
- R4: Frame `40 00 ii dd` stores `dd` in the low byte of program buffer word `ii[4:0]`. Frame `48 00 ii dd` stores it in the high byte.
- R5: Frame `4C ah al xx` writes all 32 program buffer words to the page given by bits [10:5] of the 11-bit word address `{ah,al}`. The buffer then returns to 0xFFFF in every word, so words not reloaded before the next page write are written as 0xFFFF.
- R6: Frame `C1 00 ii dd` stores `dd` in data buffer entry `ii[1:0]` and marks that entry loaded. Frame `C2 00 aa xx` writes only the loaded entries into data page `aa[7:2]`, leaves the other bytes of that page unchanged, and then clears every loaded flag.
- R7: Frame `C0 00 aa dd` sets data byte `aa` to exactly `dd`, including bits that go from 0 to 1, because the location is erased before it is written.
- R8: Frames `20 ah al xx` and `28 ah al xx` return the low and high byte of program word `{ah,al}[10:0]` on `miso` during byte 4. Frame `A0 00 aa xx` returns data byte `aa`.
- R9: A page write or byte write raises `busy` on the next cycle for exactly `WRITE_CYCLES` cycles. Load, write and unlock frames that complete while `busy` is high are discarded.
- R10: `miso` changes only on the cycle after an `sck` rising edge is detected, or on `link_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_rst | input | 1 | Synchronous link resynchronise; clears framing and unlock state |
| sck | input | 1 | Serial clock from host, sampled in the clk domain |
| mosi | input | 1 | Serial data from host, sampled on sck rising edges |
| miso | output | 1 | Serial data to host |
| busy | output | 1 | High while a memory write is in progress |

## Verification
The bench targets the data page merge. It preloads neighbouring bytes, loads only two entries, commits, and then commits again with nothing loaded after a direct byte write. A design that copies the whole buffer would overwrite the neighbours, and one that keeps stale flags would undo the byte write. It writes 0x3C and then 0xC3 to one location, so a port that only clears bits and never erases would read back 0x00. It sends a second write while the first is still busy and measures the busy window. A design that restarts the timer or accepts the second write shows the wrong length or the wrong data. It also writes an unloaded program page to catch a buffer that is not refilled with ones, and checks the echo bytes of every frame, including the 0x53 echo after a `link_rst` in the middle of a frame.

// File: rtl/spiprog_pkg.sv
package spiprog_pkg;

  localparam logic [7:0] OP_UNLOCK   = 8'hAC;
  localparam logic [7:0] UNLOCK_KEY  = 8'h53;
  localparam logic [7:0] OP_PLOAD_LO = 8'h40;
  localparam logic [7:0] OP_PLOAD_HI = 8'h48;
  localparam logic [7:0] OP_PCOMMIT  = 8'h4C;
  localparam logic [7:0] OP_PREAD_LO = 8'h20;
  localparam logic [7:0] OP_PREAD_HI = 8'h28;
  localparam logic [7:0] OP_DLOAD    = 8'hC1;
  localparam logic [7:0] OP_DCOMMIT  = 8'hC2;
  localparam logic [7:0] OP_DBYTE    = 8'hC0;
  localparam logic [7:0] OP_DREAD    = 8'hA0;

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] a_hi;
    logic [7:0] a_lo;
    logic [7:0] dat;
  } frame_t;

  function automatic logic is_read_op(logic [7:0] op);
    return (op == OP_PREAD_LO) || (op == OP_PREAD_HI) || (op == OP_DREAD);
  endfunction

  function automatic logic is_unlock(logic [7:0] op, logic [7:0] key);
    return (op == OP_UNLOCK) && (key == UNLOCK_KEY);
  endfunction

endpackage

// File: rtl/spiprog_link.sv
module spiprog_link #(
  parameter int FRAME_BITS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       link_clr,
  input  logic                       sck,
  input  logic                       mosi,
  input  logic [7:0]                 tx_next,
  output logic                       sample,
  output logic                       boundary,
  output logic [$clog2(FRAME_BITS)-4:0] byte_idx,
  output logic [FRAME_BITS-1:0]      shift_next,
  output logic                       miso
);
  localparam int CW = $clog2(FRAME_BITS);

  logic [2:0]            sck_s;
  logic [1:0]            mosi_s;
  logic [FRAME_BITS-2:0] sr;
  logic [CW-1:0]         bit_cnt;
  logic [7:0]            tx;

  // two-flop synchronisers, third sck stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      mosi_s <= {mosi_s[0], mosi};
    end
  end

  assign sample     = sck_s[1] & ~sck_s[2];
  assign boundary   = &bit_cnt[2:0];
  assign byte_idx   = bit_cnt[CW-1:3];
  assign shift_next = {sr, mosi_s[1]};
  assign miso       = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      bit_cnt <= '0;
      tx      <= '0;
    end else if (link_clr) begin
      sr      <= '0;
      bit_cnt <= '0;
      tx      <= '0;
    end else if (sample) begin
      sr      <= shift_next[FRAME_BITS-2:0];
      bit_cnt <= bit_cnt + 1'b1;
      tx      <= boundary ? tx_next : {tx[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/spiprog_pbuf.sv
module spiprog_pbuf #(
  parameter int WORD_IDX_W = 5
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ld_lo,
  input  logic                                ld_hi,
  input  logic [WORD_IDX_W-1:0]               idx,
  input  logic [7:0]                          din,
  input  logic                                refill,
  output logic [(1<<WORD_IDX_W)-1:0][15:0]    words
);
  localparam int NW = 1 << WORD_IDX_W;

  generate
    for (genvar g = 0; g < NW; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          words[g] <= 16'hFFFF;
        end else if (refill) begin
          words[g] <= 16'hFFFF;
        end else if (idx == WORD_IDX_W'(g)) begin
          if (ld_lo) words[g][7:0]  <= din;
          if (ld_hi) words[g][15:8] <= din;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/spiprog_dbuf.sv
module spiprog_dbuf #(
  parameter int BYTE_IDX_W = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ld,
  input  logic [BYTE_IDX_W-1:0]               idx,
  input  logic [7:0]                          din,
  input  logic                                flush,
  output logic [(1<<BYTE_IDX_W)-1:0][7:0]     bytes,
  output logic [(1<<BYTE_IDX_W)-1:0]          loaded
);
  localparam int NB = 1 << BYTE_IDX_W;

  generate
    for (genvar g = 0; g < NB; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bytes[g]  <= 8'hFF;
          loaded[g] <= 1'b0;
        end else if (flush) begin
          loaded[g] <= 1'b0;
        end else if (ld && idx == BYTE_IDX_W'(g)) begin
          bytes[g]  <= din;
          loaded[g] <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/spiprog_target.sv
module spiprog_target
  import spiprog_pkg::*;
#(
  parameter int PROG_ADDR_W  = 11,
  parameter int PAGE_WORD_W  = 5,
  parameter int DATA_ADDR_W  = 8,
  parameter int DPAGE_BYTE_W = 2,
  parameter int WRITE_CYCLES = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_rst,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy
);
  localparam int PW      = 1 << PAGE_WORD_W;
  localparam int PDEPTH  = 1 << PROG_ADDR_W;
  localparam int PNUM_W  = PROG_ADDR_W - PAGE_WORD_W;
  localparam int DB      = 1 << DPAGE_BYTE_W;
  localparam int DDEPTH  = 1 << DATA_ADDR_W;
  localparam int DNUM_W  = DATA_ADDR_W - DPAGE_BYTE_W;
  localparam int CNT_W   = $clog2(WRITE_CYCLES + 1);

  function automatic logic [PROG_ADDR_W-1:0] prog_addr(logic [15:0] a);
    return PROG_ADDR_W'(a);
  endfunction

  function automatic logic [DATA_ADDR_W-1:0] data_addr(logic [7:0] a);
    return DATA_ADDR_W'(a);
  endfunction

  // link
  logic        sample, boundary;
  logic [1:0]  byte_idx;
  logic [31:0] shift_next;
  logic [7:0]  tx_next;

  spiprog_link #(.FRAME_BITS(32)) u_link (
    .clk, .rst_n, .link_clr(link_rst), .sck, .mosi,
    .tx_next, .sample, .boundary, .byte_idx, .shift_next, .miso
  );

  // decode events, named for the checker
  frame_t fr;
  logic   frame_done, accept, enabled;
  logic   cmd_pld_lo, cmd_pld_hi, cmd_pwr, cmd_dld, cmd_dwr, cmd_dbw;
  logic   write_fire;
  logic [CNT_W-1:0] busy_cnt;

  assign fr         = frame_t'(shift_next);
  assign frame_done = sample & boundary & (byte_idx == 2'd3);
  assign accept     = frame_done & enabled & ~busy;
  assign cmd_pld_lo = accept & (fr.op == OP_PLOAD_LO);
  assign cmd_pld_hi = accept & (fr.op == OP_PLOAD_HI);
  assign cmd_pwr    = accept & (fr.op == OP_PCOMMIT);
  assign cmd_dld    = accept & (fr.op == OP_DLOAD);
  assign cmd_dwr    = accept & (fr.op == OP_DCOMMIT);
  assign cmd_dbw    = accept & (fr.op == OP_DBYTE);
  assign write_fire = cmd_pwr | cmd_dwr | cmd_dbw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   enabled <= 1'b0;
    else if (link_rst)            enabled <= 1'b0;
    else if (frame_done && !busy && is_unlock(fr.op, fr.a_hi))
                                  enabled <= 1'b1;
  end

  // address fields
  logic [PROG_ADDR_W-1:0] w_paddr;
  logic [DATA_ADDR_W-1:0] w_daddr;
  logic [PNUM_W-1:0]      ppage;
  logic [DNUM_W-1:0]      dpage;

  assign w_paddr = prog_addr({fr.a_hi, fr.a_lo});
  assign w_daddr = data_addr(fr.a_lo);
  assign ppage   = w_paddr[PROG_ADDR_W-1:PAGE_WORD_W];
  assign dpage   = w_daddr[DATA_ADDR_W-1:DPAGE_BYTE_W];

  // page buffers
  logic [PW-1:0][15:0] pwords;
  logic [DB-1:0][7:0]  dbytes;
  logic [DB-1:0]       dflags;

  spiprog_pbuf #(.WORD_IDX_W(PAGE_WORD_W)) u_pbuf (
    .clk, .rst_n, .ld_lo(cmd_pld_lo), .ld_hi(cmd_pld_hi),
    .idx(w_paddr[PAGE_WORD_W-1:0]), .din(fr.dat),
    .refill(cmd_pwr), .words(pwords)
  );

  spiprog_dbuf #(.BYTE_IDX_W(DPAGE_BYTE_W)) u_dbuf (
    .clk, .rst_n, .ld(cmd_dld),
    .idx(w_daddr[DPAGE_BYTE_W-1:0]), .din(fr.dat),
    .flush(cmd_dwr), .bytes(dbytes), .loaded(dflags)
  );

  // behavioural arrays, erased to all ones
  logic [15:0] pmem [PDEPTH];
  logic [7:0]  dmem [DDEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PDEPTH; i++) pmem[i] <= 16'hFFFF;
    end else if (cmd_pwr) begin
      for (int w = 0; w < PW; w++) pmem[{ppage, PAGE_WORD_W'(w)}] <= pwords[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DDEPTH; i++) dmem[i] <= 8'hFF;
    end else if (cmd_dbw) begin
      dmem[w_daddr] <= fr.dat;
    end else if (cmd_dwr) begin
      for (int b = 0; b < DB; b++)
        if (dflags[b]) dmem[{dpage, DPAGE_BYTE_W'(b)}] <= dbytes[b];
    end
  end

  // read path, evaluated as byte 3 completes
  logic [7:0]  rd_op;
  logic [15:0] rd_a16;
  logic [15:0] rd_word;
  logic [7:0]  rd_byte;

  assign rd_op   = shift_next[23:16];
  assign rd_a16  = shift_next[15:0];
  assign rd_word = pmem[prog_addr(rd_a16)];

  always_comb begin
    unique case (rd_op)
      OP_PREAD_HI: rd_byte = rd_word[15:8];
      OP_DREAD:    rd_byte = dmem[data_addr(rd_a16[7:0])];
      default:     rd_byte = rd_word[7:0];
    endcase
  end

  always_comb begin
    if (byte_idx == 2'd3)                               tx_next = 8'h00;
    else if (byte_idx == 2'd2 && enabled && is_read_op(rd_op)) tx_next = rd_byte;
    else                                                tx_next = shift_next[7:0];
  end

  // write timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cnt <= '0;
    else if (write_fire)       busy_cnt <= CNT_W'(WRITE_CYCLES);
    else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy = (busy_cnt != '0);
endmodule

// File: rtl/spiprog_target_chk.sv
module spiprog_target_chk #(
  parameter int NB    = 4,
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             link_rst,
  input logic             sample,
  input logic             frame_done,
  input logic             write_fire,
  input logic             enabled,
  input logic             cmd_dwr,
  input logic [NB-1:0]    dflags,
  input logic [CNT_W-1:0] busy_cnt,
  input logic             busy,
  input logic             miso
);
  assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(write_fire));

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(busy_cnt) == CNT_W'(1)));

  assert_drop_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_done) |=> $stable(dflags));

  assert_flags_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dwr |=> (dflags == '0));

  assert_unlock_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enabled) |-> $past(frame_done));

  assert_locked_noload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !enabled) |=> $stable(dflags));

  assert_miso_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sample) && !$past(link_rst)) |-> $stable(miso));
endmodule

bind spiprog_target spiprog_target_chk #(.NB(DB), .CNT_W(CNT_W)) u_chk (
  .clk, .rst_n, .link_rst, .sample, .frame_done, .write_fire, .enabled,
  .cmd_dwr, .dflags, .busy_cnt, .busy, .miso
);

// File: tb/test_spiprog_target.sv
`timescale 1ns/1ps
module test_spiprog_target;
  localparam int WC   = 1500;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, link_rst = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, busy;

  always #2 clk = ~clk;

  spiprog_target #(.WRITE_CYCLES(WC)) i_spiprog_target (
    .clk, .rst_n, .link_rst, .sck, .mosi, .miso, .busy
  );

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: assemble miso bytes on sck rise, pop and compare
  int         mon_bits = 0;
  logic [7:0] mon_byte = 8'h00;
  always @(posedge sck or posedge link_rst) begin
    if (link_rst) mon_bits = 0;
    else begin
      mon_byte = {mon_byte[6:0], miso};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (exp_q.size() == 0) check(1'b0, "scoreboard-empty", mon_byte, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(mon_byte == e, t, mon_byte, e);
        end
      end
    end
  end

  // busy run-length monitor
  int run_len = 0, last_run = 0;
  always @(negedge clk) begin
    if (busy) run_len++;
    else if (run_len != 0) begin last_run = run_len; run_len = 0; end
  end

  task automatic send_bit(input logic b);
    @(negedge clk) mosi = b;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic push(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // driver: pushes the expected miso bytes, then shifts the frame
  task automatic frame(input logic [7:0] b1, b2, b3, b4,
                       input bit rd, input logic [7:0] e4, input string tag);
    push(8'h00, "R2 byte1");
    push(b1, "R2 echo b1");
    push(b2, "R2 echo b2");
    push(rd ? e4 : b3, tag);
    for (int i = 31; i >= 0; i--) send_bit(({b1, b2, b3, b4} >> i) & 1);
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_data(input logic [7:0] a, input logic [7:0] e, input string tag);
    frame(8'hA0, 8'h00, a, 8'h00, 1'b1, e, tag);
  endtask

  task automatic rd_prog(input logic [10:0] w, input logic [15:0] e, input string tag);
    frame(8'h20, {5'd0, w[10:8]}, w[7:0], 8'h00, 1'b1, e[7:0], tag);
    frame(8'h28, {5'd0, w[10:8]}, w[7:0], 8'h00, 1'b1, e[15:8], tag);
  endtask

  task automatic unlock();
    frame(8'hAC, 8'h53, 8'h5A, 8'h00, 1'b0, 8'h00, "R2 unlock echo b3");
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(miso == 1'b0, "R1 miso after reset", miso, 0);

    // R3: locked port ignores a byte write
    frame(8'hC0, 8'h00, 8'h05, 8'h12, 1'b0, 8'h00, "R3 locked echo");
    check(busy == 1'b0, "R3 no write while locked", busy, 0);
    unlock();
    rd_data(8'h05, 8'hFF, "R3 R1 locked write dropped");
    rd_prog(11'h003, 16'hFFFF, "R1 erased program");

    // R7 byte write with erase, R9 busy length
    frame(8'hC0, 8'h00, 8'h05, 8'h3C, 1'b0, 8'h00, "R7 echo");
    wait_idle();
    check(last_run == WC, "R9 busy length", last_run, WC);
    rd_data(8'h05, 8'h3C, "R7 byte write");
    frame(8'hC0, 8'h00, 8'h05, 8'hC3, 1'b0, 8'h00, "R7 echo");
    wait_idle();
    rd_data(8'h05, 8'hC3, "R7 erase before write");

    // R9: second write during busy is dropped
    frame(8'hC0, 8'h00, 8'h06, 8'h11, 1'b0, 8'h00, "R9 echo");
    frame(8'hC0, 8'h00, 8'h06, 8'h22, 1'b0, 8'h00, "R9 echo");
    wait_idle();
    check(last_run == WC, "R9 busy not restarted", last_run, WC);
    rd_data(8'h06, 8'h11, "R9 write during busy dropped");

    // R6 data page merge
    frame(8'hC0, 8'h00, 8'h09, 8'h99, 1'b0, 8'h00, "R6 echo"); wait_idle();
    frame(8'hC0, 8'h00, 8'h0A, 8'hAA, 1'b0, 8'h00, "R6 echo"); wait_idle();
    frame(8'hC1, 8'h00, 8'h00, 8'h01, 1'b0, 8'h00, "R6 echo");
    frame(8'hC1, 8'h00, 8'h02, 8'h02, 1'b0, 8'h00, "R6 echo");
    frame(8'hC2, 8'h00, 8'h08, 8'h00, 1'b0, 8'h00, "R6 echo"); wait_idle();
    rd_data(8'h08, 8'h01, "R6 loaded entry 0");
    rd_data(8'h09, 8'h99, "R6 unloaded entry kept");
    rd_data(8'h0A, 8'h02, "R6 loaded entry 2");
    rd_data(8'h0B, 8'hFF, "R6 unloaded erased entry");
    frame(8'hC0, 8'h00, 8'h08, 8'h77, 1'b0, 8'h00, "R6 echo"); wait_idle();
    frame(8'hC2, 8'h00, 8'h08, 8'h00, 1'b0, 8'h00, "R6 echo"); wait_idle();
    rd_data(8'h08, 8'h77, "R6 flags cleared after commit");
    rd_data(8'h0A, 8'h02, "R6 flags cleared entry 2");

    // R4 R5 program page
    frame(8'h40, 8'h00, 8'h03, 8'h34, 1'b0, 8'h00, "R4 echo");
    frame(8'h48, 8'h00, 8'h03, 8'h12, 1'b0, 8'h00, "R4 echo");
    frame(8'h40, 8'h00, 8'h1F, 8'hEF, 1'b0, 8'h00, "R4 echo");
    frame(8'h48, 8'h00, 8'h1F, 8'hBE, 1'b0, 8'h00, "R4 echo");
    frame(8'h4C, 8'h00, 8'hA0, 8'h00, 1'b0, 8'h00, "R5 echo"); wait_idle();
    rd_prog(11'h0A3, 16'h1234, "R4 R5 R8 word 3 of page 5");
    rd_prog(11'h0BF, 16'hBEEF, "R4 R5 R8 last word of page 5");
    rd_prog(11'h0A4, 16'hFFFF, "R5 unloaded word");
    rd_prog(11'h003, 16'hFFFF, "R5 other page untouched");
    frame(8'h4C, 8'h00, 8'hC0, 8'h00, 1'b0, 8'h00, "R5 echo"); wait_idle();
    rd_prog(11'h0C3, 16'hFFFF, "R5 buffer refilled");
    rd_prog(11'h0A3, 16'h1234, "R5 earlier page kept");

    // R3 link resync mid-frame
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    @(negedge clk) link_rst = 1'b1;
    @(negedge clk) link_rst = 1'b0;
    repeat (2) @(negedge clk);
    check(miso == 1'b0, "R3 miso cleared by link_rst", miso, 0);
    frame(8'hC0, 8'h00, 8'h20, 8'h44, 1'b0, 8'h00, "R3 relocked echo");
    check(busy == 1'b0, "R3 relocked after link_rst", busy, 0);
    unlock();
    rd_data(8'h20, 8'hFF, "R3 relocked write dropped");
    rd_data(8'h06, 8'h11, "R8 data read after resync");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule